// File: doc/BRIEF.md
# Duplicated Byte-Substitution Stage with Mismatch Detection

This block performs the byte-substitution step of a 128-bit block cipher round and checks its own result. The input state is fed to two independent substitution layers. Each layer has one S-box per state byte. Every S-box computes its result arithmetically: a multiplicative inverse in GF(2^8) over the polynomial x^8+x^4+x^3+x+1 and a bit-level affine map. No lookup table is stored. A comparator checks the two layers byte by byte. Any bitwise disagreement raises a fault flag, so a corrupted value is never passed on unreported.

A mode pin selects the inverse substitution for decryption, and both copies follow that selection. The substituted state comes from copy A. It is registered together with an output strobe and the fault flag, so all three appear one cycle after an accepted input. The fault flag can be made to persist with a sticky-enable pin. A test-only mask input flips chosen bits of copy B's result. A bench can use it to confirm that every single-bit corruption is caught.

Top module: `dup_sbox_stage`

## Requirements
- R1: In forward mode (`inv_mode`=0), each output byte k (bits 8k+7..8k) is the S-box of input byte k. The S-box takes the field inverse, with 0x00 mapped to 0x00, and then applies the affine map with bit i = b[i]^b[(i+4)%8]^b[(i+5)%8]^b[(i+6)%8]^b[(i+7)%8]^c[i], where c = 0x63. Examples: 0x00 gives 0x63, 0x01 gives 0x7C and 0x53 gives 0xED.
- R2: In inverse mode (`inv_mode`=1), each output byte is the inverse S-box of its input byte, so 0x63 gives 0x00, 0x7C gives 0x01 and 0xED gives 0x53.
- R3: `out_valid` equals `in_valid` delayed by one clock. `state_out` is loaded only on a clock where `in_valid`=1 and otherwise holds its value.
- R4: When `in_valid`=1 and `inject_mask` is non-zero, `fault` is 1 after the next clock. This holds for every single-bit mask, and `state_out` still carries the correct copy-A result.
- R5: When `in_valid`=1, `inject_mask`=0 and `sticky_en`=0, `fault` is 0 after the next clock.
- R6: While `sticky_en`=1, a raised `fault` stays 1 on every following clock. The next value of `fault` is (`in_valid` AND mismatch) OR (`sticky_en` AND `fault`).
- R7: With `sticky_en`=0, a clock where `in_valid`=0 leaves `fault` at 0, whatever value `inject_mask` holds.
- R8: While `rst`=1, the clock edge clears `state_out` to 0, `out_valid` to 0 and `fault` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input state is valid this cycle |
| inv_mode | input | 1 | 0: forward substitution, 1: inverse substitution |
| sticky_en | input | 1 | 1: hold the fault flag once raised |
| state_in | input | 128 | Input state, byte k at bits 8k+7..8k |
| inject_mask | input | 128 | Test-only XOR mask applied to copy B's result |
| state_out | output | 128 | Registered substituted state from copy A |
| out_valid | output | 1 | Registered strobe, in_valid delayed one cycle |
| fault | output | 1 | Registered mismatch flag |

## Verification
The bench builds the block with its default of 16 byte lanes, which is the full 128-bit state. That width lets all 256 byte values in both directions pass through in sixteen vectors. It also lets a sweep walk a single-bit mask across all 128 positions of copy B. Expected values come from a bench model that finds field inverses by exhaustive search. That model is independent of the square-and-multiply path in the design.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FWD_CONST = 8'h63;
  localparam logic [BYTE_W-1:0] INV_CONST = 8'h05;
  localparam logic [BYTE_W-1:0] FIELD_RED = 8'h1B;
  localparam logic [BYTE_W-1:0] INV_EXP   = 8'd254;

  function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                              input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] acc;
    logic [BYTE_W-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[BYTE_W-1] ? ((sh << 1) ^ FIELD_RED) : (sh << 1);
    end
    return acc;
  endfunction

  // x^254 equals x^-1 for non-zero x and yields 0 for x = 0
  function automatic logic [BYTE_W-1:0] gf_inv(input logic [BYTE_W-1:0] x);
    logic [BYTE_W-1:0] r;
    r = 8'h01;
    for (int i = BYTE_W-1; i >= 0; i--) begin
      r = gf_mul(r, r);
      if (INV_EXP[i]) r = gf_mul(r, x);
    end
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] affine_fwd(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] o;
    for (int i = 0; i < BYTE_W; i++) begin
      o[i] = b[i] ^ b[(i+4)%BYTE_W] ^ b[(i+5)%BYTE_W] ^ b[(i+6)%BYTE_W]
           ^ b[(i+7)%BYTE_W] ^ FWD_CONST[i];
    end
    return o;
  endfunction

  function automatic logic [BYTE_W-1:0] affine_inv(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] o;
    for (int i = 0; i < BYTE_W; i++) begin
      o[i] = b[(i+7)%BYTE_W] ^ b[(i+5)%BYTE_W] ^ b[(i+2)%BYTE_W] ^ INV_CONST[i];
    end
    return o;
  endfunction

endpackage

// File: rtl/sbox_unit.sv
module sbox_unit
  import dsb_pkg::*;
(
  input  logic              inv_mode,
  input  logic [BYTE_W-1:0] d_in,
  output logic [BYTE_W-1:0] d_out
);

  logic [BYTE_W-1:0] inv_src;
  logic [BYTE_W-1:0] inv_res;

  // the field inverse is shared by both directions: the mode only moves the affine step
  always_comb begin
    inv_src = inv_mode ? affine_inv(d_in) : d_in;
    inv_res = gf_inv(inv_src);
    d_out   = inv_mode ? inv_res : affine_fwd(inv_res);
  end

endmodule

// File: rtl/sub_layer.sv
module sub_layer
  import dsb_pkg::*;
#(
  parameter int NBYTES = 16,
  localparam int W = NBYTES * BYTE_W
) (
  input  logic         inv_mode,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    sbox_unit u_sbox (
      .inv_mode (inv_mode),
      .d_in     (d_in [k*BYTE_W +: BYTE_W]),
      .d_out    (d_out[k*BYTE_W +: BYTE_W])
    );
  end

endmodule

// File: rtl/mismatch_cmp.sv
module mismatch_cmp
  import dsb_pkg::*;
#(
  parameter int NBYTES = 16,
  localparam int W = NBYTES * BYTE_W
) (
  input  logic [W-1:0]      side_a,
  input  logic [W-1:0]      side_b,
  output logic [NBYTES-1:0] byte_diff,
  output logic              any_diff
);

  for (genvar k = 0; k < NBYTES; k++) begin : g_cmp
    assign byte_diff[k] = |(side_a[k*BYTE_W +: BYTE_W] ^ side_b[k*BYTE_W +: BYTE_W]);
  end

  assign any_diff = |byte_diff;

endmodule

// File: rtl/dup_sbox_stage.sv
module dup_sbox_stage
  import dsb_pkg::*;
#(
  parameter int NBYTES = 16,
  localparam int W = NBYTES * BYTE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         inv_mode,
  input  logic         sticky_en,
  input  logic [W-1:0] state_in,
  input  logic [W-1:0] inject_mask,
  output logic [W-1:0] state_out,
  output logic         out_valid,
  output logic         fault
);

  logic [W-1:0]      sub_a;
  logic [W-1:0]      sub_b;
  logic [W-1:0]      sub_b_tap;
  logic [NBYTES-1:0] byte_diff;
  logic              any_diff;

  sub_layer #(.NBYTES(NBYTES)) u_copy_a (
    .inv_mode (inv_mode),
    .d_in     (state_in),
    .d_out    (sub_a)
  );

  sub_layer #(.NBYTES(NBYTES)) u_copy_b (
    .inv_mode (inv_mode),
    .d_in     (state_in),
    .d_out    (sub_b)
  );

  assign sub_b_tap = sub_b ^ inject_mask;

  mismatch_cmp #(.NBYTES(NBYTES)) u_cmp (
    .side_a    (sub_a),
    .side_b    (sub_b_tap),
    .byte_diff (byte_diff),
    .any_diff  (any_diff)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_out <= '0;
      out_valid <= 1'b0;
      fault     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) state_out <= sub_a;
      fault <= (in_valid & any_diff) | (sticky_en & fault);
    end
  end

  a_r3_valid_rise: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r3_valid_low: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(state_out));
  a_r4_single_bit: assert property (@(posedge clk) disable iff (rst)
    (in_valid && $countones(inject_mask) == 1) |=> fault);
  a_r5_clean: assert property (@(posedge clk) disable iff (rst)
    (in_valid && inject_mask == '0 && !sticky_en) |=> !fault);
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (fault && sticky_en) |=> fault);
  a_r7_idle: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !sticky_en) |=> !fault);

endmodule

// File: tb/test_dup_sbox_stage.sv
module test_dup_sbox_stage;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 16;
  localparam int W  = NB * 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         inv_mode;
  logic         sticky_en;
  logic [W-1:0] state_in;
  logic [W-1:0] inject_mask;
  logic [W-1:0] state_out;
  logic         out_valid;
  logic         fault;

  int n_vec = 0;
  int n_bad = 0;

  logic [7:0] fwd_tab [256];
  logic [7:0] inv_tab [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  dup_sbox_stage #(.NBYTES(NB)) i_dup_sbox_stage (
    .clk(clk), .rst(rst), .in_valid(in_valid), .inv_mode(inv_mode),
    .sticky_en(sticky_en), .state_in(state_in), .inject_mask(inject_mask),
    .state_out(state_out), .out_valid(out_valid), .fault(fault)
  );

  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11B << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] m_inv(input logic [7:0] x);
    if (x == 8'h00) return 8'h00;
    for (int y = 1; y < 256; y++) if (m_mul(x, 8'(y)) == 8'h01) return 8'(y);
    return 8'h00;
  endfunction

  function automatic logic [7:0] m_fwd(input logic [7:0] x);
    logic [7:0] b, o, c;
    b = m_inv(x);
    c = 8'h63;
    for (int i = 0; i < 8; i++)
      o[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ c[i];
    return o;
  endfunction

  function automatic logic [W-1:0] expect_state(input logic [W-1:0] s, input logic md);
    logic [W-1:0] r;
    for (int k = 0; k < NB; k++)
      r[k*8 +: 8] = md ? inv_tab[s[k*8 +: 8]] : fwd_tab[s[k*8 +: 8]];
    return r;
  endfunction

  function automatic logic [W-1:0] rand_state();
    logic [W-1:0] r;
    for (int k = 0; k < W/32; k++) r[k*32 +: 32] = $urandom();
    return r;
  endfunction

  task automatic chk(input logic ok, input string req,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, then wait to the next falling edge: one rising edge consumed
  task automatic step(input logic v, input logic md, input logic stk,
                      input logic [W-1:0] s, input logic [W-1:0] m);
    @(negedge clk);
    in_valid = v; inv_mode = md; sticky_en = stk; state_in = s; inject_mask = m;
    @(negedge clk);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    logic [W-1:0] held;
    logic [W-1:0] s;
    logic [W-1:0] e;
    void'($urandom(32'h5A17_C0DE));
    for (int i = 0; i < 256; i++) fwd_tab[i] = m_fwd(8'(i));
    for (int i = 0; i < 256; i++) inv_tab[fwd_tab[i]] = 8'(i);

    rst = 1'b1; in_valid = 0; inv_mode = 0; sticky_en = 0;
    state_in = '0; inject_mask = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(state_out == '0, "R8 state_out", state_out, '0);
    chk(out_valid == 1'b0, "R8 out_valid", W'(out_valid), '0);
    chk(fault == 1'b0, "R8 fault", W'(fault), '0);
    rst = 1'b0;

    // R1 known answers
    s = '0; s[7:0] = 8'h00; s[15:8] = 8'h01; s[23:16] = 8'h53;
    step(1, 0, 0, s, '0);
    chk(state_out[7:0] == 8'h63, "R1 kat 00", W'(state_out[7:0]), W'(8'h63));
    chk(state_out[15:8] == 8'h7C, "R1 kat 01", W'(state_out[15:8]), W'(8'h7C));
    chk(state_out[23:16] == 8'hED, "R1 kat 53", W'(state_out[23:16]), W'(8'hED));
    chk(out_valid == 1'b1, "R3 valid after one clock", W'(out_valid), W'(1));

    // R2 known answers
    s = '0; s[7:0] = 8'h63; s[15:8] = 8'h7C; s[23:16] = 8'hED;
    step(1, 1, 0, s, '0);
    chk(state_out[23:0] == 24'h530100, "R2 kat", W'(state_out[23:0]), W'(24'h530100));

    // R1/R2 exhaustive over all byte values in both modes
    for (int md = 0; md < 2; md++) begin
      for (int v = 0; v < 256 / NB; v++) begin
        for (int k = 0; k < NB; k++) s[k*8 +: 8] = 8'(v * NB + k);
        step(1, md[0], 0, s, '0);
        e = expect_state(s, md[0]);
        chk(state_out == e, md ? "R2 sweep" : "R1 sweep", state_out, e);
        chk(fault == 1'b0, "R5 sweep clean", W'(fault), '0);
      end
    end

    // random vectors, both modes
    for (int n = 0; n < 300; n++) begin
      logic md;
      md = 1'($urandom());
      s = rand_state();
      step(1, md, 0, s, '0);
      e = expect_state(s, md);
      chk(state_out == e, md ? "R2 random" : "R1 random", state_out, e);
      chk(fault == 1'b0, "R5 random clean", W'(fault), '0);
    end

    // R4 single-bit injection sweep
    for (int b = 0; b < W; b++) begin
      logic [W-1:0] m;
      m = '0; m[b] = 1'b1;
      s = rand_state();
      step(1, b[0], 0, s, m);
      e = expect_state(s, b[0]);
      chk(fault == 1'b1, "R4 single bit flagged", W'(fault), W'(1));
      chk(state_out == e, "R4 data from copy A", state_out, e);
    end

    // R7 clean valid clears, idle with mask ignored, R3 hold
    s = rand_state();
    step(1, 0, 0, s, '0);
    held = expect_state(s, 0);
    chk(fault == 1'b0, "R7 clears after clean input", W'(fault), '0);
    step(0, 1, 0, rand_state(), {W{1'b1}});
    chk(fault == 1'b0, "R7 idle mask ignored", W'(fault), '0);
    chk(out_valid == 1'b0, "R3 idle valid low", W'(out_valid), '0);
    chk(state_out == held, "R3 idle hold", state_out, held);
    step(1, 0, 0, rand_state(), 128'h1 << 77);
    step(0, 0, 0, s, '0);
    chk(fault == 1'b0, "R7 non-sticky drop", W'(fault), '0);

    // R6 sticky behaviour
    step(1, 0, 1, rand_state(), 128'h1 << 5);
    chk(fault == 1'b1, "R6 raise", W'(fault), W'(1));
    for (int n = 0; n < 3; n++) begin
      step(n[0], 0, 1, rand_state(), '0);
      chk(fault == 1'b1, "R6 held", W'(fault), W'(1));
    end
    step(1, 0, 0, rand_state(), '0);
    chk(fault == 1'b0, "R6 release", W'(fault), '0);

    // R8 reset mid-run
    step(1, 0, 1, rand_state(), 128'h1);
    @(negedge clk); rst = 1'b1; in_valid = 0;
    @(negedge clk); rst = 1'b0;
    chk(state_out == '0, "R8 mid reset data", state_out, '0);
    chk(fault == 1'b0, "R8 mid reset fault", W'(fault), '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule